// File: doc/BRIEF.md
# LIN Break Detector

This block sits behind the bit sampler of a UART receiver. It watches the recovered receive level, one sample per bit time, and reports a LIN break, which is a low level that lasts longer than any legal character. The sampler marks each bit time with a one-cycle valid strobe. The detector counts consecutive low samples and raises a sticky break flag once the count reaches the selected threshold. An interrupt line follows the flag when the interrupt enable is set.

The threshold is either 10 or 11 bit times. It is chosen with a length-select value and a write strobe. The choice can only change while the block is disabled. Each break sets the flag once. Software clears the flag with a clear pulse. When the block is disabled, the run count is held at zero and no break can be seen.

Top module: `lin_brk_detect`

## Requirements
- R1: With the short length selected (stored length code 0), the flag is low after 9 consecutive low valid samples. It is high in the cycle after the 10th consecutive low valid sample.
- R2: With the long length selected (stored length code 1), the flag is still low after 10 consecutive low valid samples. It is high in the cycle after the 11th.
- R3: `brk_irq` is high exactly when `brk_flag` is high and `irq_en` is 1.
- R4: A length write (`len_wr` = 1) made while `blk_en` is 1 has no effect. The stored length changes only when `len_wr` is 1 and `blk_en` is 0.
- R5: A high valid sample returns the low-run count to zero. A run of 9 lows, then 1 high, then 9 lows does not set the flag under the short length.
- R6: The flag sets once per break. After a clear, further low samples in the same break do not set it again. Only a high sample and a new full run of lows set it again.
- R7: The flag stays set until `flag_clr` is 1. A clear in the same cycle as a new detection leaves the flag set.
- R8: While `blk_en` is 0, the count is held at zero and the flag cannot set. Low samples taken while disabled do not count toward a later run.
- R9: After reset, `brk_flag` and `brk_irq` are 0 and the short length is selected.
- R10: Cycles with `bit_valid` = 0 neither advance nor reset the count, whatever `bit_rx` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_en | input | 1 | Block enable; locks the length setting while 1 |
| len_wr | input | 1 | Write strobe for the length select |
| len_sel | input | 1 | Length code: 0 = 10 bit times, 1 = 11 bit times |
| bit_valid | input | 1 | One-cycle strobe marking a bit-time sample |
| bit_rx | input | 1 | Sampled receive level |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the break flag |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `bit_valid` is a strobe whose paired `bit_rx` is meaningful only in strobed cycles. The assertions on the length lock and on the cleared count depend only on `blk_en` and `len_wr`, so the stimulus may toggle these freely. The bench changes every input at the falling edge. It deliberately puts non-strobed high levels on `bit_rx` between low samples, and it tries a length write while enabled. This shows that those inputs are ignored without breaking any property.

// File: rtl/lbd_pkg.sv
// Package: shared types for the break detector.
// Assumes nothing beyond a single clock domain.
package lbd_pkg;
    // Stored break-length code; the value is the software encoding.
    typedef enum logic {
        LEN_SHORT = 1'b0,
        LEN_LONG  = 1'b1
    } brk_len_e;
endpackage

// File: rtl/lbd_cfg.sv
// Module: holds the break-length setting.
// A write is taken only while the block is disabled.
// Assumes len_wr and len_sel are synchronous to clk.
module lbd_cfg
    import lbd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     blk_en,
    input  logic     len_wr,
    input  logic     len_sel,
    output brk_len_e len_mode
);
    // Update the stored length only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_mode <= LEN_SHORT;
        else if (len_wr && !blk_en)
            len_mode <= brk_len_e'(len_sel);
    end
endmodule

// File: rtl/lbd_run_cnt.sv
// Module: counts consecutive low bit samples and pulses hit on the sample
// that reaches the threshold. It re-arms only after a high sample.
// Assumes bit_valid marks exactly one cycle per bit time.
module lbd_run_cnt
    import lbd_pkg::*;
#(
    parameter int SHORT_BITS = 10,
    parameter int LONG_BITS  = 11,
    parameter int CNT_W      = $clog2(LONG_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_en,
    input  logic             bit_valid,
    input  logic             bit_rx,
    input  brk_len_e         len_mode,
    output logic [CNT_W-1:0] low_cnt,
    output logic             hit
);
    logic             armed;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   thr;
    logic             low_smp;

    // Select the threshold and form the lookahead count.
    always_comb begin
        thr     = (len_mode == LEN_LONG) ? (CNT_W+1)'(LONG_BITS)
                                         : (CNT_W+1)'(SHORT_BITS);
        cnt_inc = {1'b0, low_cnt} + (CNT_W+1)'(1);
        low_smp = blk_en && bit_valid && !bit_rx;
        hit     = low_smp && armed && (cnt_inc >= thr);
    end

    // Track the low run and the once-per-break arming.
    always_ff @(posedge clk) begin
        if (!rst_n || !blk_en) begin
            low_cnt <= '0;
            armed   <= 1'b1;
        end else if (bit_valid) begin
            if (bit_rx) begin
                low_cnt <= '0;
                armed   <= 1'b1;
            end else begin
                if (low_cnt < CNT_W'(LONG_BITS))
                    low_cnt <= cnt_inc[CNT_W-1:0];
                if (hit)
                    armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lbd_flag.sv
// Module: sticky break flag and the interrupt gate.
// A set wins over a clear in the same cycle.
// Assumes hit is a single-cycle pulse.
module lbd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic brk_flag,
    output logic brk_irq
);
    // Hold the flag, with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_flag <= 1'b0;
        else if (hit)
            brk_flag <= 1'b1;
        else if (flag_clr)
            brk_flag <= 1'b0;
    end

    // Gate the interrupt with its enable.
    always_comb brk_irq = brk_flag && irq_en;
endmodule

// File: rtl/lin_brk_detect.sv
// Module: top of the break detector. It joins the length lock, the run
// counter and the flag. Assumes one sample strobe per bit time.
module lin_brk_detect
    import lbd_pkg::*;
#(
    parameter int SHORT_BITS = 10,
    parameter int LONG_BITS  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_en,
    input  logic len_wr,
    input  logic len_sel,
    input  logic bit_valid,
    input  logic bit_rx,
    input  logic irq_en,
    input  logic flag_clr,
    output logic brk_flag,
    output logic brk_irq
);
    localparam int CNT_W = $clog2(LONG_BITS + 1);

    brk_len_e         len_mode;
    logic [CNT_W-1:0] low_cnt;
    logic             hit;

    lbd_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en),
        .len_wr(len_wr), .len_sel(len_sel), .len_mode(len_mode)
    );

    lbd_run_cnt #(
        .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS), .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en),
        .bit_valid(bit_valid), .bit_rx(bit_rx), .len_mode(len_mode),
        .low_cnt(low_cnt), .hit(hit)
    );

    lbd_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flag_clr(flag_clr),
        .irq_en(irq_en), .brk_flag(brk_flag), .brk_irq(brk_irq)
    );
endmodule

// File: rtl/lbd_chk.sv
// Checker: properties of the break detector, bound to the top module.
// Assumes all inputs are synchronous to clk.
module lbd_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_en,
    input logic             len_wr,
    input logic             bit_valid,
    input logic             bit_rx,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             brk_flag,
    input logic             brk_irq,
    input logic             len_mode,
    input logic [CNT_W-1:0] low_cnt
);
    // R1 R2: a flag rise follows a low strobed sample.
    assert_rise_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(blk_en && bit_valid && !bit_rx));

    // R3: interrupt follows flag and enable.
    assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq == (brk_flag && irq_en));

    // R4: length is locked while enabled.
    assert_len_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en || !len_wr) |=> $stable(len_mode));

    // R5: a high strobed sample empties the run.
    assert_high_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && bit_valid && bit_rx) |=> (low_cnt == '0));

    // R7: the flag holds without a clear.
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !flag_clr) |=> brk_flag);

    // R8: disabled means no new flag and an empty count.
    assert_no_set_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_en && !brk_flag) |=> !brk_flag);
    assert_cnt_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> (low_cnt == '0));

    // R10: non-strobed cycles leave the count alone.
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && !bit_valid) |=> $stable(low_cnt));
endmodule

bind lin_brk_detect lbd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .len_wr(len_wr),
    .bit_valid(bit_valid), .bit_rx(bit_rx), .irq_en(irq_en),
    .flag_clr(flag_clr), .brk_flag(brk_flag), .brk_irq(brk_irq),
    .len_mode(len_mode), .low_cnt(low_cnt)
);

// File: tb/sim_lin_brk_detect.sv
`timescale 1ns/1ps
module sim_lin_brk_detect;
    logic clk = 1'b0;
    logic rst_n, blk_en, len_wr, len_sel, bit_valid, bit_rx, irq_en, flag_clr;
    logic brk_flag, brk_irq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lin_brk_detect u0 (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .len_wr(len_wr),
        .len_sel(len_sel), .bit_valid(bit_valid), .bit_rx(bit_rx),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .brk_flag(brk_flag), .brk_irq(brk_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One strobed sample; returns at the falling edge after its update.
    // Between samples the line is left high but not strobed.
    task automatic smp(input logic b);
        @(negedge clk);
        bit_valid = 1'b1; bit_rx = b;
        @(negedge clk);
        bit_valid = 1'b0; bit_rx = 1'b1;
    endtask

    task automatic lows(input int n);
        for (int i = 0; i < n; i++) smp(1'b0);
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic set_len(input logic l);
        @(negedge clk); blk_en = 1'b0; len_wr = 1'b1; len_sel = l;
        @(negedge clk); len_wr = 1'b0; blk_en = 1'b1;
    endtask

    task automatic restart();
        smp(1'b1); clr_flag();
    endtask

    task automatic t_reset();
        chk("R9 flag after reset", brk_flag, 1'b0);
        chk("R9 irq after reset", brk_irq, 1'b0);
        lows(9);  chk("R9 default short, 9 lows", brk_flag, 1'b0);
        lows(1);  chk("R9 default short, 10 lows", brk_flag, 1'b1);
        restart();
    endtask

    task automatic t_short();
        lows(9);  chk("R1 9 lows", brk_flag, 1'b0);
        lows(1);  chk("R1 10th low", brk_flag, 1'b1);
        restart();
    endtask

    task automatic t_long();
        set_len(1'b1);
        lows(10); chk("R2 10 lows", brk_flag, 1'b0);
        lows(1);  chk("R2 11th low", brk_flag, 1'b1);
        restart();
    endtask

    task automatic t_lock();
        @(negedge clk); len_wr = 1'b1; len_sel = 1'b0;
        @(negedge clk); len_wr = 1'b0;
        lows(10); chk("R4 write while enabled ignored, 10 lows", brk_flag, 1'b0);
        lows(1);  chk("R4 still long, 11th low", brk_flag, 1'b1);
        restart();
        set_len(1'b0);
    endtask

    task automatic t_break_run();
        lows(9); smp(1'b1); lows(9);
        chk("R5 high sample resets run", brk_flag, 1'b0);
        lows(1);
        chk("R5 new run completes", brk_flag, 1'b1);
        restart();
    endtask

    task automatic t_once();
        lows(10); chk("R6 first set", brk_flag, 1'b1);
        clr_flag(); lows(12);
        chk("R6 no re-set in same break", brk_flag, 1'b0);
        smp(1'b1); lows(10);
        chk("R6 re-set after high", brk_flag, 1'b1);
        restart();
    endtask

    task automatic t_hold_race();
        lows(10);
        repeat (5) @(negedge clk);
        chk("R7 flag holds", brk_flag, 1'b1);
        smp(1'b1); lows(9);
        @(negedge clk); bit_valid = 1'b1; bit_rx = 1'b0; flag_clr = 1'b1;
        @(negedge clk); bit_valid = 1'b0; bit_rx = 1'b1; flag_clr = 1'b0;
        chk("R7 detection beats clear", brk_flag, 1'b1);
        clr_flag();
        chk("R7 clear", brk_flag, 1'b0);
        smp(1'b1);
    endtask

    task automatic t_irq();
        irq_en = 1'b0; lows(10);
        chk("R3 irq off when disabled", brk_irq, 1'b0);
        @(negedge clk); irq_en = 1'b1; #1;
        chk("R3 irq on", brk_irq, 1'b1);
        clr_flag();
        chk("R3 irq drops with flag", brk_irq, 1'b0);
        smp(1'b1);
    endtask

    task automatic t_disabled();
        @(negedge clk); blk_en = 1'b0;
        lows(12);
        chk("R8 no flag while disabled", brk_flag, 1'b0);
        @(negedge clk); blk_en = 1'b1;
        lows(9);
        chk("R8 disabled lows not counted", brk_flag, 1'b0);
        lows(1);
        chk("R8 fresh run after enable", brk_flag, 1'b1);
        restart();
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 10; i++) begin
            smp(1'b0);
            repeat (3) @(negedge clk);
            if (i == 8) chk("R10 gaps, 9 lows", brk_flag, 1'b0);
        end
        chk("R10 gaps with high idle level", brk_flag, 1'b1);
        restart();
    endtask

    initial begin
        rst_n = 1'b0; blk_en = 1'b0; len_wr = 1'b0; len_sel = 1'b0;
        bit_valid = 1'b0; bit_rx = 1'b1; irq_en = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; blk_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_long();
        t_lock();
        t_break_run();
        t_once();
        t_hold_race();
        t_irq();
        t_disabled();
        t_gaps();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule